// File: doc/BRIEF.md
# Vectored Maskable Interrupt Controller

This block sits beside the core of a small 8-bit microcontroller and decides when the core should take an interrupt. It watches six request sources and latches a pending flag for each one. Three of the sources are levels: two comparator outputs and an external pin. A falling edge on any of these sets its flag. The other three are single-cycle pulses: two timer overflows and an A/D end-of-conversion.

Software controls the block through two byte-wide control registers. These hold a global enable, one enable per source and the six flags, and the CPU can read and write them. Software can therefore raise or drop any request directly.

When a request is enabled, the global enable is set, the flag is pending and the core's hardware stack is not full, the block accepts the request. It asserts an acknowledge strobe for that cycle and presents the source's fixed vector address. On the following clock edge it drops both the accepted flag and the global enable, so the handler runs unnested until software sets the global enable again. Any pending flag also drives a wake-up output, whatever the enables are.

Top module: `vec_intc`

## Requirements
- R1: After reset, both control registers read 0x00, `irq_ack` is 0, `irq_vector` is 0x00 and `wake` is 0.
- R2: Control register A (`reg_sel`=0) holds the following bits:
  - bit0: global enable.
  - bits 1, 2 and 3: the enables for comparator 0, comparator 1 and external.
  - bits 4, 5 and 6: the flags for comparator 0, comparator 1 and external.
  - bit7: always reads 0.
- R3: Control register B (`reg_sel`=1) holds the following bits:
  - bits 0, 1 and 2: the enables for timer 0, timer 1 and A/D.
  - bits 4, 5 and 6: the flags for timer 0, timer 1 and A/D.
  - bits 3 and 7: always read 0, and writes to them are ignored.
- R4: A falling edge on `cmp0_in`, `cmp1_in` or `ext_in` sets that source's flag on the next clock edge. A rising edge sets nothing.
- R5: A one-cycle high on `tmr0_ovf`, `tmr1_ovf` or `adc_done` sets that source's flag on the next clock edge.
- R6: `irq_ack` is high exactly when all of the following hold: the global enable is set, `stack_full` is low, and some source has both its enable and its flag set.
- R7: While `irq_ack` is high, `irq_vector` gives the vector of the accepted source: comparator 0 0x04, comparator 1 0x08, external 0x0C, timer 0 0x10, timer 1 0x14, A/D 0x18. Otherwise it is 0x00.
- R8: On the clock edge that ends an acknowledge cycle, the accepted flag and the global enable both clear. Other pending flags are kept.
- R9: A request that arrives while the global enable is clear still sets its flag. It is accepted once software sets the global enable.
- R10: `wake` is high whenever any flag is set, regardless of the enables.
- R11: When several enabled requests are pending, the one accepted is the highest in this order: comparator 0, comparator 1, external, timer 0, timer 1, A/D.
- R12: Software writes update the flag bits directly, both setting and clearing them. If a hardware set and a software clear of the same flag land in the same cycle, the flag ends up set.
- R13: While `stack_full` is high, no request is acknowledged. Pending flags stay set until the stack frees up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Control register select (0 = A, 1 = B) |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register (combinational) |
| cmp0_in | input | 1 | Comparator 0 output level |
| cmp1_in | input | 1 | Comparator 1 output level |
| ext_in | input | 1 | External interrupt pin level |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| adc_done | input | 1 | A/D end-of-conversion pulse |
| stack_full | input | 1 | Core's hardware stack is full |
| irq_ack | output | 1 | Interrupt accepted this cycle |
| irq_vector | output | 8 | Vector address of the accepted source |
| wake | output | 1 | Some flag is pending |

## Verification
The edge inputs are driven both low and high, so a falling-edge detector can be told apart from a level or rising-edge one. The pulse inputs are driven for a single cycle to confirm that they latch.

Acceptance is tried four ways:
- with the global enable clear;
- with the stack full and then freed;
- with a per-source enable clear;
- with all conditions met.

Together these four show that each condition gates on its own.

A run with all six flags pending, re-enabling the global enable after each acknowledge, walks the full priority order and every vector. A write that clears a flag in the same cycle as its hardware pulse separates the two possible orders of set and clear.

// File: rtl/vec_intc.sv
module vec_intc #(
  parameter int VEC_W    = 8,
  parameter int VEC_STEP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_sel,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  input  logic             cmp0_in,
  input  logic             cmp1_in,
  input  logic             ext_in,
  input  logic             tmr0_ovf,
  input  logic             tmr1_ovf,
  input  logic             adc_done,
  input  logic             stack_full,
  output logic             irq_ack,
  output logic [VEC_W-1:0] irq_vector,
  output logic             wake
);
  localparam int NSRC = 6;

  logic            gie;
  logic [NSRC-1:0] en, flag;
  logic [2:0]      prev;

  wire [2:0]      lvl    = {ext_in, cmp1_in, cmp0_in};
  wire [NSRC-1:0] hw_set = {adc_done, tmr1_ovf, tmr0_ovf, prev & ~lvl};
  wire [NSRC-1:0] ready  = en & flag;
  wire [NSRC-1:0] grant  = ready & (~ready + 1'b1);
  wire            wr_a   = wr_en & ~reg_sel;
  wire            wr_b   = wr_en & reg_sel;

  assign irq_ack = gie & ~stack_full & (|ready);
  assign wake    = |flag;

  wire [NSRC-1:0] clr = irq_ack ? grant : '0;
  wire [NSRC-1:0] flag_sw = {wr_b ? wr_data[6:4] : flag[5:3],
                             wr_a ? wr_data[6:4] : flag[2:0]};

  logic [VEC_W-1:0] vec;
  always_comb begin
    vec = '0;
    for (int i = 0; i < NSRC; i++)
      if (grant[i]) vec = VEC_W'(VEC_STEP * (i + 1));
  end
  assign irq_vector = irq_ack ? vec : '0;

  assign rd_data = reg_sel ? {1'b0, flag[5:3], 1'b0, en[5:3]}
                           : {1'b0, flag[2:0], en[2:0], gie};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie  <= 1'b0;
      en   <= '0;
      flag <= '0;
      prev <= '0;
    end else begin
      prev <= lvl;
      flag <= (flag_sw & ~clr) | hw_set;
      if (wr_a) en[2:0] <= wr_data[3:1];
      if (wr_b) en[5:3] <= wr_data[2:0];
      gie  <= (wr_a ? wr_data[0] : gie) & ~irq_ack;
    end
  end
endmodule

// File: rtl/vec_intc_chk.sv
module vec_intc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_ack,
  input logic [7:0] irq_vector,
  input logic       wake,
  input logic       stack_full,
  input logic       tmr0_ovf,
  input logic       gie,
  input logic [5:0] flag
);
  AST_ACK_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> !stack_full); // R13
  AST_ACK_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> gie); // R6
  AST_ACK_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !gie); // R8
  AST_VEC_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (irq_vector != 8'h00 && irq_vector[1:0] == 2'b00 && irq_vector <= 8'h18)); // R7
  AST_VEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_ack |-> irq_vector == 8'h00); // R7
  AST_TMR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    tmr0_ovf |=> flag[3]); // R5
  AST_ACK_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> wake); // R10
endmodule

bind vec_intc vec_intc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_ack(irq_ack), .irq_vector(irq_vector),
  .wake(wake), .stack_full(stack_full), .tmr0_ovf(tmr0_ovf),
  .gie(gie), .flag(flag)
);

// File: tb/test_vec_intc.sv
module test_vec_intc;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, reg_sel = 0, wr_en = 0;
  logic [7:0] wr_data = 0, rd_data, irq_vector;
  logic cmp0_in = 1, cmp1_in = 1, ext_in = 1;
  logic tmr0_ovf = 0, tmr1_ovf = 0, adc_done = 0, stack_full = 0;
  logic irq_ack, wake;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_intc i_vec_intc (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .cmp0_in(cmp0_in), .cmp1_in(cmp1_in), .ext_in(ext_in),
    .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf), .adc_done(adc_done),
    .stack_full(stack_full), .irq_ack(irq_ack), .irq_vector(irq_vector), .wake(wake)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    reg_sel = sel; #1; v = rd_data;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); reg_sel = sel; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(0, v); check("R1 reg A", v, 8'h00);
    rd(1, v); check("R1 reg B", v, 8'h00);
    check("R1 ack", {7'b0, irq_ack}, 8'h00);
    check("R1 vector", irq_vector, 8'h00);
    check("R1 wake", {7'b0, wake}, 8'h00);
  endtask

  task automatic t_edges;
    logic [7:0] v;
    @(negedge clk); cmp0_in = 0;
    @(negedge clk); rd(0, v); check("R4 cmp0 fall", v, 8'h10);
    check("R10 wake", {7'b0, wake}, 8'h01);
    wr(0, 8'h00);
    cmp0_in = 1;
    @(negedge clk); @(negedge clk); rd(0, v); check("R4 rising ignored", v, 8'h00);
    check("R10 wake low", {7'b0, wake}, 8'h00);
    cmp1_in = 0; ext_in = 0;
    @(negedge clk); rd(0, v); check("R4 cmp1+ext fall", v, 8'h60);
    @(negedge clk); rd(0, v); check("R4 level low holds only", v, 8'h60);
    wr(0, 8'h00); cmp1_in = 1; ext_in = 1;
  endtask

  task automatic t_pulses;
    logic [7:0] v;
    @(negedge clk); tmr0_ovf = 1;
    @(negedge clk); tmr0_ovf = 0; rd(1, v); check("R5 tmr0", v, 8'h10);
    tmr1_ovf = 1;
    @(negedge clk); tmr1_ovf = 0; adc_done = 1;
    @(negedge clk); adc_done = 0; rd(1, v); check("R5 tmr1+adc", v, 8'h70);
    wr(1, 8'hFF); rd(1, v); check("R3 unused bits", v, 8'h77);
    wr(0, 8'hFE); rd(0, v); check("R2 layout", v, 8'h7E);
    check("R9 no ack gie clear", {7'b0, irq_ack}, 8'h00);
    wr(0, 8'h00); wr(1, 8'h00);
  endtask

  task automatic t_accept;
    logic [7:0] v;
    wr(0, 8'h02);
    @(negedge clk); cmp0_in = 0;
    @(negedge clk); cmp0_in = 1; rd(0, v); check("R9 pending", v, 8'h12);
    check("R9 no ack", {7'b0, irq_ack}, 8'h00);
    wr(0, 8'h13);
    check("R6 ack", {7'b0, irq_ack}, 8'h01);
    check("R7 vector cmp0", irq_vector, 8'h04);
    @(negedge clk); rd(0, v); check("R8 cleared", v, 8'h02);
    check("R8 ack drops", {7'b0, irq_ack}, 8'h00);
    wr(0, 8'h11); rd(0, v);
    check("R6 enable clear blocks", {7'b0, irq_ack}, 8'h00);
    wr(0, 8'h02);
  endtask

  task automatic t_stack;
    logic [7:0] v;
    stack_full = 1;
    wr(0, 8'h13);
    check("R13 blocked", {7'b0, irq_ack}, 8'h00);
    @(negedge clk); rd(0, v); check("R13 held", v, 8'h13);
    stack_full = 0; #1;
    check("R13 released ack", {7'b0, irq_ack}, 8'h01);
    check("R7 vector", irq_vector, 8'h04);
    @(negedge clk); rd(0, v); check("R8 after stack", v, 8'h02);
  endtask

  task automatic t_priority;
    logic [7:0] v;
    wr(1, 8'h77);
    wr(0, 8'h7E);
    for (int k = 1; k <= 6; k++) begin
      rd(0, v);
      wr(0, v | 8'h01);
      check("R11 order", {7'b0, irq_ack}, 8'h01);
      check("R11 vector", irq_vector, 8'(4 * k));
      @(negedge clk);
    end
    rd(0, v); check("R11 all served A", v, 8'h0E);
    rd(1, v); check("R11 all served B", v, 8'h07);
    check("R10 idle wake", {7'b0, wake}, 8'h00);
  endtask

  task automatic t_sw;
    logic [7:0] v;
    @(negedge clk); reg_sel = 1; wr_data = 8'h07; wr_en = 1; tmr0_ovf = 1;
    @(negedge clk); wr_en = 0; tmr0_ovf = 0; rd(1, v);
    check("R12 hw beats sw clear", v, 8'h17);
    wr(1, 8'h27); rd(1, v); check("R12 sw set/clear", v, 8'h27);
    wr(1, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_edges;
    t_pulses;
    t_accept;
    t_stack;
    t_priority;
    t_sw;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule